// File: doc/BRIEF.md
# Banked GPIO Port Register Block

This block holds the software-visible state for one bank of general-purpose pins. The bank has four ports of eight pins each. A pin number splits into a port field (number bits [4:3]) and a bit field (number bits [2:0]), so pin 8p+n is bit n of port p. Each port has three writable registers: function select (GPIO or alternate function), direction (drive enable) and output value. It also has a read-only level register that shows the pad inputs after a two-flop synchronizer.

Software reaches the registers over a simple synchronous bus with address, write data, write strobe, read strobe and a registered read data return. Every writable register also has a masked alias 0x800 above its plain address. For a write to an alias, data bits [15:8] act as per-bit write enables for data bits [7:0]. Software can therefore set or clear single pins without a read-modify-write sequence. To turn a pin into an output, software writes its output value first and then sets the drive enable. On the pad side, the block presents the output values, the drive enables and the function-select bits for all 32 pins.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is asserted and after it is released, every function-select, direction and output-value bit is 0. All pads are therefore undriven GPIO inputs, and reads of those registers return 0.
- R2: Plain register addresses are: function select 0x00 + 4p, direction 0x10 + 4p, output value 0x20 + 4p, level 0x30 + 4p, for port p = 0..3. A write to a plain writable address loads data bits [7:0] into the whole register, whatever the upper data bits hold. A read returns the register in bits [7:0] and zero above.
- R3: A write to the alias address (plain address + 0x800) of a writable register changes only register bit n where data bit 8+n is 1, and loads that bit from data bit n. All other bits keep their value.
- R4: The level register of port p returns pad_in[8p+7:8p]. A pad change becomes visible through the synchronizer two clock edges after it is sampled, so a read strobed on the edge that completes the second stage still returns the old level. Writes to the level register or its alias change no state.
- R5: pad_out[8p+n], pad_oe[8p+n] and pad_gpio[8p+n] equal bit n of the output-value, direction and function-select registers of port p.
- R6: Read data is registered on the clock edge that samples the read strobe. It appears after that edge and holds its value until the next read.
- R7: Any unmapped address reads as zero, and writes to it change no state. Unmapped means any of the following: address bits [1:0] non-zero, address bits [10:7] non-zero, register group 0x40–0x7F, the level-register alias, or any read of an alias address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address within the bank |
| bus_wdata | input | 32 | Write data; bits [15:8] are per-bit enables for alias writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables |
| pad_gpio | output | 32 | Per-pin GPIO (1) or alternate function (0) select |

## Verification
Plain writes use several byte patterns with non-zero junk in the upper data bits, applied to every port and register. This catches swapped ports or groups, as well as writes that wrongly honour the enable byte. Alias writes step through sixteen enable masks with data unrelated to the mask, which separates "load where enabled" from "load everything" and from "OR in". A single pin is walked across all 32 positions through the output alias to confirm the pad mapping. Pad-level patterns, writes aimed at unmapped and read-only addresses, and back-to-back reads around a pad change show the synchronizer depth, read-only behaviour, zero reads and the read latency.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  // index of each writable register group within one port
  localparam int unsigned IDX_SEL  = 0;   // function select
  localparam int unsigned IDX_DIR  = 1;   // drive enable
  localparam int unsigned IDX_DAT  = 2;   // output value
  localparam int unsigned NUM_WGRP = 3;
  // address group code of the read-only level register
  localparam logic [1:0]  GRP_LVL  = 2'd3;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= din;
      stg2_q <= stg1_q;
    end
  end

  assign dout = stg2_q;
endmodule

// File: rtl/gpb_mreg.sv
module gpb_mreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_plain,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wen,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_load;

  always_comb begin
    q_nxt = q_r;
    if (wr_plain) begin
      q_nxt = wdata;
    end else if (wr_mask) begin
      q_nxt = (q_r & ~wen) | (wdata & wen);
    end
  end

  assign q_load = wr_plain | wr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (q_load) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  // bits without an enable must survive an alias write
  assert_masked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask && !wr_plain |=> ((q_r ^ $past(q_r)) & ~$past(wen)) == '0);

  // enabled bits of an alias write take the data bit
  assert_masked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask && !wr_plain |=> ((q_r ^ $past(wdata)) & $past(wen)) == '0);

  // without a write strobe the register holds
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_plain && !wr_mask |=> $stable(q_r));
endmodule

// File: rtl/gpb_decode.sv
module gpb_decode
  import gpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PORTS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr,
  output logic [PORTS*NUM_WGRP-1:0] wr_plain,
  output logic [PORTS*NUM_WGRP-1:0] wr_mask,
  output logic                      rd_hit,
  output logic [1:0]                rd_grp,
  output logic [1:0]                rd_port
);
  logic       up_ok;
  logic       is_alias;
  logic       bank_ok;
  logic       aligned;
  logic       port_ok;
  logic       base_ok;
  logic [2:0] grp_raw;
  logic [1:0] prt;

  if (ADDR_W > 12) begin : g_upper
    assign up_ok = ~|addr[ADDR_W-1:12];
  end else begin : g_no_upper
    assign up_ok = 1'b1;
  end

  assign is_alias = addr[11];
  assign bank_ok  = ~|addr[10:7];
  assign grp_raw  = addr[6:4];
  assign prt      = addr[3:2];
  assign aligned  = ~|addr[1:0];
  assign port_ok  = (32'(prt) < PORTS);
  assign base_ok  = up_ok & bank_ok & aligned & port_ok;

  always_comb begin
    wr_plain = '0;
    wr_mask  = '0;
    for (int p = 0; p < PORTS; p++) begin
      for (int g = 0; g < NUM_WGRP; g++) begin
        if (wr && base_ok && prt == p[1:0] && grp_raw == g[2:0]) begin
          wr_plain[p*NUM_WGRP+g] = !is_alias;
          wr_mask[p*NUM_WGRP+g]  = is_alias;
        end
      end
    end
  end

  assign rd_hit  = base_ok & !is_alias & !grp_raw[2];
  assign rd_grp  = grp_raw[1:0];
  assign rd_port = prt;

  // a bus write reaches at most one register
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_plain, wr_mask}));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PORTS  = 4,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [PORTS*PORT_W-1:0] pad_in,
  output logic [PORTS*PORT_W-1:0] pad_out,
  output logic [PORTS*PORT_W-1:0] pad_oe,
  output logic [PORTS*PORT_W-1:0] pad_gpio
);
  localparam int unsigned PINS = PORTS * PORT_W;
  localparam int unsigned NREG = PORTS * NUM_WGRP;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];

  logic [NREG-1:0]   wr_plain;
  logic [NREG-1:0]   wr_mask;
  logic              rd_hit;
  logic [1:0]        rd_grp;
  logic [1:0]        rd_port;
  logic [PORT_W-1:0] regq [NREG];
  logic [PINS-1:0]   lvl_sync;

  gpb_decode #(.ADDR_W(ADDR_W), .PORTS(PORTS)) u_decode (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wr_plain (wr_plain),
    .wr_mask  (wr_mask),
    .rd_hit   (rd_hit),
    .rd_grp   (rd_grp),
    .rd_port  (rd_port)
  );

  gpb_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pad_in),
    .dout  (lvl_sync)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    for (genvar g = 0; g < NUM_WGRP; g++) begin : g_reg
      gpb_mreg #(.W(PORT_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .wr_plain (wr_plain[p*NUM_WGRP+g]),
        .wr_mask  (wr_mask[p*NUM_WGRP+g]),
        .wdata    (bus_wdata[PORT_W-1:0]),
        .wen      (bus_wdata[2*PORT_W-1:PORT_W]),
        .q        (regq[p*NUM_WGRP+g])
      );
    end
    assign pad_gpio[p*PORT_W +: PORT_W] = regq[p*NUM_WGRP+IDX_SEL];
    assign pad_oe[p*PORT_W +: PORT_W]   = regq[p*NUM_WGRP+IDX_DIR];
    assign pad_out[p*PORT_W +: PORT_W]  = regq[p*NUM_WGRP+IDX_DAT];
  end

  // read path: select next-state, then register on the strobe
  logic [PORT_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_nxt;
  logic [DATA_W-1:0] rdata_r;

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < PORTS; p++) begin
      for (int g = 0; g < NUM_WGRP; g++) begin
        if (rd_hit && rd_port == p[1:0] && rd_grp == g[1:0]) begin
          rd_val = regq[p*NUM_WGRP+g];
        end
      end
      if (rd_hit && rd_port == p[1:0] && rd_grp == GRP_LVL) begin
        rd_val = lvl_sync[p*PORT_W +: PORT_W];
      end
    end
  end

  assign rdata_nxt = {{(DATA_W-PORT_W){1'b0}}, rd_val};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_r <= '0;
    end else if (bus_rd) begin
      rdata_r <= rdata_nxt;
    end
  end

  assign bus_rdata = rdata_r;

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rd && !rd_hit |=> bus_rdata == '0);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rd |=> bus_rdata[DATA_W-1:PORT_W] == '0);
endmodule

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic [31:0] pad_gpio;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [7:0] mdl [4][3];   // group 0 select, 1 direction, 2 output

  initial clk = 1'b0;
  always #10 clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_gpio(pad_gpio)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] adr(int g, int p, bit alias_sel);
    return 12'((alias_sel ? 'h800 : 0) + g * 16 + p * 4);
  endfunction

  function automatic logic [31:0] pads(int g);
    logic [31:0] v;
    for (int p = 0; p < 4; p++) v[p*8 +: 8] = mdl[p][g];
    return v;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_pads(string tag);
    chk({tag, " R5 pad_gpio"}, pad_gpio, pads(0));
    chk({tag, " R5 pad_oe"},   pad_oe,   pads(1));
    chk({tag, " R5 pad_out"},  pad_out,  pads(2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  pats [6];
    logic [31:0] lvls [5];
    logic [11:0] bad  [12];
    pats = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h3C, 8'h81};
    lvls = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5C3_F00F, 32'h8000_0001};
    bad  = '{12'h040, 12'h05C, 12'h070, 12'h07C, 12'h830, 12'h83C,
             12'h880, 12'h100, 12'h421, 12'h002, 12'h023, 12'h811};
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    pad_in = 32'hDEAD_BEEF;
    for (int p = 0; p < 4; p++) for (int g = 0; g < 3; g++) mdl[p][g] = '0;
    repeat (4) @(negedge clk);
    chk("R1 pads in reset", {pad_gpio | pad_oe | pad_out}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk_pads("R1 after reset");
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 3; g++) begin
        rd(adr(g, p, 0), d);
        chk("R1 register reset value", d, 32'h0);
      end

    // R2: plain writes with junk in the upper data bits
    foreach (pats[k]) begin
      for (int p = 0; p < 4; p++)
        for (int g = 0; g < 3; g++) begin
          logic [7:0] v;
          v = pats[k] ^ 8'(p * 37 + g * 11);
          wr(adr(g, p, 0), {24'h5AC35A ^ 24'(k), v});
          mdl[p][g] = v;
          rd(adr(g, p, 0), d);
          chk("R2 plain write readback", d, {24'h0, v});
        end
      chk_pads("R2 after plain sweep");
    end

    // R5: walk one driven pin across the bank through the output alias
    for (int p = 0; p < 4; p++) begin
      wr(adr(2, p, 0), 32'h0);
      mdl[p][2] = '0;
    end
    for (int i = 0; i < 32; i++) begin
      logic [7:0] b;
      b = 8'(1 << (i % 8));
      wr(adr(2, i / 8, 1), {16'h0, b, b});
      chk("R5 single pin output mapping", pad_out, 32'(1) << i);
      wr(adr(2, i / 8, 1), {16'h0, b, 8'h00});
    end
    chk("R5 walk cleared", pad_out, 32'h0);

    // R3: alias writes over sixteen enable masks
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 3; g++)
        for (int k = 0; k < 16; k++) begin
          logic [7:0] en;
          logic [7:0] dv;
          en = 8'(k * 17) ^ 8'(p * 3 + g);
          dv = ~en ^ 8'(k * 29 + p);
          wr(adr(g, p, 1), {16'hFFFF, en, dv});
          mdl[p][g] = (mdl[p][g] & ~en) | (dv & en);
          rd(adr(g, p, 0), d);
          chk("R3 masked write result", d, {24'h0, mdl[p][g]});
        end
    chk_pads("R3 after masked sweep");

    // R4: level register, read-only
    foreach (lvls[k]) begin
      @(negedge clk);
      pad_in = lvls[k];
      repeat (3) @(negedge clk);
      for (int p = 0; p < 4; p++) begin
        wr(adr(3, p, 0), ~lvls[k]);
        wr(adr(3, p, 1), 32'h0000_FFFF);
        rd(adr(3, p, 0), d);
        chk("R4 level readback", d, {24'h0, lvls[k][p*8 +: 8]});
      end
      chk_pads("R4 writes to level register");
    end

    // R4: synchronizer depth
    @(negedge clk);
    pad_in = 32'h0000_00C6;
    rd(adr(3, 0, 0), d);
    chk("R4 level before second stage", d, {24'h0, lvls[4][7:0]});
    rd(adr(3, 0, 0), d);
    chk("R4 level after second stage", d, 32'h0000_00C6);

    // R7: unmapped addresses
    foreach (bad[k]) begin
      wr(bad[k], 32'hFFFF_FFFF);
      chk_pads("R7 unmapped write");
      rd(adr(0, 1, 0), d);
      rd(bad[k], d);
      chk("R7 unmapped read", d, 32'h0);
    end
    for (int g = 0; g < 3; g++) begin
      rd(adr(0, 3, 0), d);
      rd(adr(g, 3, 1), d);
      chk("R7 alias read", d, 32'h0);
    end

    // R6: latency and hold
    rd(adr(1, 2, 0), d);
    chk("R6 read value", d, {24'h0, mdl[2][1]});
    @(negedge clk);
    bus_addr = adr(2, 0, 0); bus_rd = 1'b1;
    #1;
    chk("R6 data before edge", bus_rdata, {24'h0, mdl[2][1]});
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R6 data after edge", bus_rdata, {24'h0, mdl[0][2]});
    bus_addr = adr(0, 1, 0);
    repeat (5) @(negedge clk);
    chk("R6 data held", bus_rdata, {24'h0, mdl[0][2]});

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {pad_gpio | pad_oe | pad_out}, 32'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule